// File: doc/BRIEF.md
# Repeated-Subtraction Sequential Divider

This block divides one unsigned operand by another. It subtracts the divisor from a working dividend register until the subtraction would need a borrow, and it counts the subtractions that succeed. The count is the quotient. The value left in the working register is the remainder. It spends one clock per successful subtraction, so it uses very little logic: one subtractor, three registers and a three-state controller.

A requester puts both operands on the inputs and pulses `start` while the block is idle. It then waits for `done`. The results stay valid and unchanged until the requester raises `ack`, and then the block goes back to idle. The comparison comes from the borrow out of the subtractor. The dividend update and the quotient increment are Mealy-style controls, so a single cycle both tests and updates. A zero divisor does not hang the block: it ends the operation at once with a saturated quotient.

Top module: `rsub_divider`

## Requirements
- R1: After reset, `done`, `quotient` and `remainder` are all zero.
- R2: A `start` sampled high while idle loads both operands and clears the quotient. When the divisor is nonzero, the controller enters the counting state, and `done` stays low on the following cycle.
- R3: Each counting cycle in which the working value is at least the divisor replaces the working value with the difference and adds one to the quotient, both at the same edge.
- R4: A borrow from the subtractor (working value below divisor) ends the iteration. `done` rises exactly Q+2 rising edges after start is sampled, counting the sampling edge, where Q is the final quotient.
- R5: The final `quotient` equals floor(X/Y) and `remainder` equals X mod Y for the operands captured at start (for example, 13 and 5 give 2 and 3).
- R6: A zero divisor at start makes `done` high after the sampling edge alone. `quotient` is then all ones and `remainder` is the dividend.
- R7: While `done` is high and `ack` is low, `done`, `quotient` and `remainder` do not change, whatever `start`, `x_in` and `y_in` do.
- R8: `ack` high while `done` is high makes `done` low after the next edge. `ack` in any other state has no effect.
- R9: `start` raised while counting is ignored. The result still matches the operands captured at the original start.
- R10: The operand width is the parameter `WIDTH` (default 8), and the quotient has the same width, so 255/1 gives quotient 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division (acted on only when idle) |
| ack | input | 1 | Acknowledge results (acted on only when done) |
| x_in | input | WIDTH | Dividend |
| y_in | input | WIDTH | Divisor |
| done | output | 1 | Results valid |
| quotient | output | WIDTH | Quotient |
| remainder | output | WIDTH | Remainder / working dividend |

## Verification
The hardest situation to reach from the ports is a stray `start` or `ack` that lands while the block is counting, because that window only exists between the sampling edge and the borrow cycle. The stimulus starts divisions with a quotient of at least one and then, on the very next cycle, pulses `start` and `ack` together with different operands. The bench then checks that neither the latency nor the result moved. Random operands weighted toward tiny divisors give long counting runs, and separate cases cover zero divisors and full-width dividends.

// File: rtl/rsub_div_pkg.sv
package rsub_div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_DONE  = 2'd2
    } div_state_e;
endpackage

// File: rtl/rsub_div_sub.sv
module rsub_div_sub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] minuend,
    input  logic [WIDTH-1:0] subtrahend,
    output logic [WIDTH-1:0] diff,
    output logic             borrow
);
    localparam int EXT = WIDTH + 1;
    logic [EXT-1:0] wide;

    always_comb begin
        wide   = {1'b0, minuend} - {1'b0, subtrahend};
        diff   = wide[WIDTH-1:0];
        borrow = wide[EXT-1];
    end
endmodule

// File: rtl/rsub_div_ctrl.sv
module rsub_div_ctrl
    import rsub_div_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       ack,
    input  logic       borrow,
    input  logic       div_zero,
    output div_state_e state,
    output logic       load_ops,
    output logic       fill_ones,
    output logic       step
);
    typedef struct packed {
        div_state_e st;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        load_ops  = 1'b0;
        fill_ones = 1'b0;
        step      = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    load_ops  = 1'b1;
                    fill_ones = div_zero;
                    r_d.st    = div_zero ? ST_DONE : ST_COUNT;
                end
            end
            ST_COUNT: begin
                // Mealy: compare and update within one cycle
                if (borrow) begin
                    r_d.st = ST_DONE;
                end else begin
                    step = 1'b1;
                end
            end
            ST_DONE: begin
                if (ack) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.st;
endmodule

// File: rtl/rsub_div_dp.sv
module rsub_div_dp #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_ops,
    input  logic             fill_ones,
    input  logic             step,
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    output logic [WIDTH-1:0] x_q,
    output logic [WIDTH-1:0] y_q,
    output logic [WIDTH-1:0] q_q,
    output logic             borrow,
    output logic             div_zero
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [WIDTH-1:0] x;
        logic [WIDTH-1:0] y;
        logic [WIDTH-1:0] q;
    } dp_regs_t;

    dp_regs_t         r_d, r_q;
    logic [WIDTH-1:0] diff;

    rsub_div_sub #(.WIDTH(WIDTH)) u_sub (
        .minuend    (r_q.x),
        .subtrahend (r_q.y),
        .diff       (diff),
        .borrow     (borrow)
    );

    assign div_zero = (y_in == '0);

    always_comb begin
        r_d = r_q;
        if (load_ops) begin
            r_d.x = x_in;
            r_d.y = y_in;
            r_d.q = fill_ones ? ALL_ONES : '0;
        end else if (step) begin
            r_d.x = diff;
            r_d.q = r_q.q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign x_q = r_q.x;
    assign y_q = r_q.y;
    assign q_q = r_q.q;
endmodule

// File: rtl/rsub_divider.sv
module rsub_divider
    import rsub_div_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ack,
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    output logic             done,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder
);
    div_state_e       state;
    logic             load_ops, fill_ones, step, borrow, div_zero;
    logic [WIDTH-1:0] x_q, y_q, q_q;

    rsub_div_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ack       (ack),
        .borrow    (borrow),
        .div_zero  (div_zero),
        .state     (state),
        .load_ops  (load_ops),
        .fill_ones (fill_ones),
        .step      (step)
    );

    rsub_div_dp #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_ops  (load_ops),
        .fill_ones (fill_ones),
        .step      (step),
        .x_in      (x_in),
        .y_in      (y_in),
        .x_q       (x_q),
        .y_q       (y_q),
        .q_q       (q_q),
        .borrow    (borrow),
        .div_zero  (div_zero)
    );

    assign done      = (state == ST_DONE);
    assign quotient  = q_q;
    assign remainder = x_q;
endmodule

// File: rtl/rsub_divider_chk.sv
module rsub_divider_chk
    import rsub_div_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             ack,
    input logic [WIDTH-1:0] x_in,
    input logic [WIDTH-1:0] y_in,
    input logic             done,
    input logic [WIDTH-1:0] quotient,
    input logic [WIDTH-1:0] remainder,
    input div_state_e       state,
    input logic [WIDTH-1:0] y_q,
    input logic             borrow
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && y_in != '0) |=>
        (state == ST_COUNT && quotient == '0 && remainder == $past(x_in) && !done));

    a_r3_quot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && !borrow) |=>
        (quotient == $past(quotient) + ONE && remainder == $past(remainder) - $past(y_q)));

    a_r4_borrow_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && borrow) |=> (done && $stable(quotient) && $stable(remainder)));

    a_r5_rem_below_div: assert property (@(posedge clk) disable iff (!rst_n)
        (done && y_q != '0) |-> (remainder < y_q));

    a_r6_zero_div: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && y_in == '0) |=>
        (done && quotient == {WIDTH{1'b1}} && remainder == $past(x_in)));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ack) |=> (done && $stable(quotient) && $stable(remainder)));

    a_r8_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ack) |=> !done);

    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT) |=> (state != ST_IDLE));
endmodule

bind rsub_divider rsub_divider_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ack       (ack),
    .x_in      (x_in),
    .y_in      (y_in),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .state     (state),
    .y_q       (y_q),
    .borrow    (borrow)
);

// File: tb/rsub_divider_tb.sv
`timescale 1ns/1ps
module rsub_divider_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         ack = 1'b0;
    logic [W-1:0] x_in = '0;
    logic [W-1:0] y_in = '0;
    logic         done;
    logic [W-1:0] quotient, remainder;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rsub_divider #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ack(ack),
        .x_in(x_in), .y_in(y_in),
        .done(done), .quotient(quotient), .remainder(remainder)
    );

    function automatic logic [W-1:0] exp_q(input logic [W-1:0] x, input logic [W-1:0] y);
        return (y == 0) ? {W{1'b1}} : W'(x / y);
    endfunction

    function automatic logic [W-1:0] exp_r(input logic [W-1:0] x, input logic [W-1:0] y);
        return (y == 0) ? x : W'(x % y);
    endfunction

    function automatic int exp_lat(input logic [W-1:0] x, input logic [W-1:0] y);
        return (y == 0) ? 1 : int'(x / y) + 2;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // disturb: pulse start+ack with other operands one cycle into counting (R9, R8)
    task automatic run_div(input logic [W-1:0] x, input logic [W-1:0] y, input bit disturb);
        int n;
        logic [W-1:0] eq, er;
        eq = exp_q(x, y);
        er = exp_r(x, y);
        @(negedge clk);
        x_in = x; y_in = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        if (disturb && y != 0 && eq >= 1) begin
            chk(done == 1'b0, "R2 not done after start", int'(done), 0);
            start = 1'b1; ack = 1'b1; x_in = ~x; y_in = y + 8'd1;
            @(negedge clk);
            start = 1'b0; ack = 1'b0;
            n = 2;
        end
        while (!done && n < 600) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R4 done reached", int'(done), 1);
        chk(n == exp_lat(x, y), (y == 0) ? "R6 latency" : "R4 latency", n, exp_lat(x, y));
        chk(quotient == eq, (y == 0) ? "R6 quotient" : (disturb ? "R9 quotient" : "R5 quotient"),
            int'(quotient), int'(eq));
        chk(remainder == er, (y == 0) ? "R6 remainder" : (disturb ? "R9 remainder" : "R5 remainder"),
            int'(remainder), int'(er));
        for (int k = 0; k < int'($urandom % 4); k++) begin
            start = 1'b1; x_in = W'($urandom); y_in = W'($urandom);
            @(negedge clk);
            chk(done && quotient == eq && remainder == er, "R7 hold in done",
                int'(quotient), int'(eq));
        end
        start = 1'b0;
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk(done == 1'b0, "R8 ack releases", int'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] rx, ry;
        void'($urandom(32'd457));
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(quotient == '0, "R1 quotient", int'(quotient), 0);
        chk(remainder == '0, "R1 remainder", int'(remainder), 0);
        rst_n = 1'b1;
        // R8: ack while idle has no effect; block still idle and starts normally
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        chk(done == 1'b0, "R8 ack idle ignored", int'(done), 0);
        run_div(8'd13, 8'd5, 1'b0);      // R5 worked example
        run_div(8'd13, 8'd5, 1'b1);      // R9 disturbed
        run_div(8'd4, 8'd9, 1'b0);       // R4 borrow on first compare
        run_div(8'd9, 8'd9, 1'b0);       // R3 exact single step
        run_div(8'd0, 8'd3, 1'b0);
        run_div(8'd200, 8'd0, 1'b0);     // R6 zero divisor
        run_div(8'd255, 8'd1, 1'b0);     // R10 full-width quotient
        run_div(8'd255, 8'd1, 1'b1);     // R9 long disturbed run
        run_div(8'd255, 8'd255, 1'b0);
        for (int i = 0; i < 60; i++) begin
            rx = W'($urandom);
            ry = ($urandom % 4 == 0) ? W'($urandom % 4) : W'($urandom);
            run_div(rx, ry, ($urandom % 3) == 0);
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule